// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block runs the target-bus half of a delayed read that a bridge has queued on behalf of a waiting initiator. It accepts one read request at a time, with an address, a bus command, a prefetchable flag and the number of DWORDs the initiator asked for. It then issues read attempts on a simplified bus-master interface. Each attempt is reported back with a termination kind and the number of data phases that completed.

Attempts that move no data are repeated with the same address, command and length. The repetition stops on the first attempt that transfers data, on a master abort, on a target abort, or once a parameterised number of empty attempts has been reached. The block then presents a completion record to the initiator-side logic and holds it until that logic acknowledges it. The record carries a code, the DWORD count and a flag telling the initiator side whether to end its transaction with a disconnect.

A target abort leaves sticky status flags set on both sides of the bridge. Running out of attempts raises a one-cycle system-error pulse when that report is enabled.

Top module: `drd_retry_ctrl`

## Requirements
- R1: After reset, req_ready is 1, and cpl_valid, att_start, serr_pulse, tgt_rcvd_tabort and ini_sig_tabort are all 0.
- R2: Every attempt carries the latched request address and command. Its length att_dwords is the requested count for a prefetchable read and 1 for a non-prefetchable read. An attempt repeated after a retry is identical to the first.
- R3: An attempt that moves no data is repeated, with att_start high for one cycle in the cycle right after att_done. Such an attempt is one that ends in retry (att_term=1), or in normal (0) or disconnect (2) with att_xfers=0.
- R4: A prefetchable read that ends normal with data completes with code 0 and a count equal to the transferred DWORDs (capped at att_dwords). cpl_disc is 1 exactly when the requested count exceeds that count.
- R5: A non-prefetchable read that ends normal with data completes with code 0, and cpl_disc is always 1.
- R6: An attempt ending in target disconnect (att_term=2) with data completes with code 0 and the transferred count. cpl_disc is 1 exactly when the requested count exceeds it.
- R7: A master abort (att_term=4) completes with code 1 and count 0, and leaves both abort status flags unchanged.
- R8: A target abort (att_term=3) completes with code 2 and count 0. It sets tgt_rcvd_tabort and ini_sig_tabort, which then stay set until reset.
- R9: After LIMIT consecutive no-data attempts the block completes with code 3 and issues no further attempt. serr_pulse is high for exactly the cycle in which cpl_valid rises when cfg_serr_en is 1, and stays 0 when cfg_serr_en is 0.
- R10: cpl_valid and the completion fields hold steady until cpl_ack. While a request is in progress req_ready is 0, and req_valid is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Queued read request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | AW | Read start address |
| req_cmd | input | 4 | Bus read command |
| req_pref | input | 1 | Target range is prefetchable |
| req_dwords | input | CW | DWORDs the initiator requested |
| cfg_serr_en | input | 1 | Enables the system-error report on attempt exhaustion |
| att_start | output | 1 | One-cycle pulse starting a bus attempt |
| att_addr | output | AW | Attempt address |
| att_cmd | output | 4 | Attempt command |
| att_dwords | output | CW | DWORDs to fetch in this attempt |
| att_done | input | 1 | Attempt finished this cycle |
| att_term | input | 3 | Termination: 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| att_xfers | input | CW | Data phases completed in the attempt |
| cpl_valid | output | 1 | Completion record valid |
| cpl_code | output | 2 | 0 data, 1 master abort, 2 target abort, 3 attempts exhausted |
| cpl_count | output | CW | DWORDs available to the initiator |
| cpl_disc | output | 1 | Initiator side ends with disconnect |
| cpl_ack | input | 1 | Initiator side consumed the record |
| tgt_rcvd_tabort | output | 1 | Sticky: target abort received on the target side |
| ini_sig_tabort | output | 1 | Sticky: target abort signalled on the initiator side |
| serr_pulse | output | 1 | One-cycle system-error report |

## Verification
The bench goes after three groups of corner cases. The first is the disconnect decision at its edges: a fetch exactly as long as the request, one shorter than it, and a non-prefetchable single DWORD. A design that compared with the wrong sense or ignored the prefetch flag would tell the initiator to disconnect, or not, in the wrong cases. The second is the no-data paths, meaning a plain retry and a disconnect or normal ending with zero transfers. A block that treated those as data would complete early with a count of zero. The third is the exhaustion boundary. With a small limit the bench counts the attempts exactly and checks the error pulse in both enable states, so an off-by-one counter shows up as one attempt too many or too few. A pulse that is level instead of single-cycle is caught as well.

// File: rtl/drd_pkg.sv
package drd_pkg;

  localparam logic [2:0] TERM_NORMAL = 3'd0;
  localparam logic [2:0] TERM_RETRY  = 3'd1;
  localparam logic [2:0] TERM_DISC   = 3'd2;
  localparam logic [2:0] TERM_TABORT = 3'd3;
  localparam logic [2:0] TERM_MABORT = 3'd4;

  localparam logic [1:0] CPL_DATA    = 2'd0;
  localparam logic [1:0] CPL_MABORT  = 2'd1;
  localparam logic [1:0] CPL_TABORT  = 2'd2;
  localparam logic [1:0] CPL_TIMEOUT = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_CPL} drd_state_e;

  // length of one bus attempt: a full request only when prefetching is allowed
  function automatic logic [15:0] attempt_len(input logic pref, input logic [15:0] want);
    return pref ? want : 16'd1;
  endfunction

  // DWORDs actually usable: transfers capped at the attempt length
  function automatic logic [15:0] usable(input logic [15:0] xfers, input logic [15:0] len);
    return (xfers > len) ? len : xfers;
  endfunction

  // no data moved: the attempt has to be repeated
  function automatic logic empty_attempt(input logic [2:0] term, input logic [15:0] xfers);
    case (term)
      TERM_NORMAL, TERM_DISC: return (xfers == 16'd0);
      TERM_TABORT, TERM_MABORT: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/drd_attempt_ctr.sv
module drd_attempt_ctr #(
  parameter int LIMIT = 1 << 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_hit
);
  localparam int CTRW = $clog2(LIMIT + 1);
  localparam logic [CTRW-1:0] LAST = CTRW'(LIMIT - 1);

  logic [CTRW-1:0] cnt_q;

  assign last_hit = inc && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr || last_hit) cnt_q <= '0;
    else if (inc)             cnt_q <= cnt_q + 1'b1;
  end

  assert_ctr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_ctr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |=> (cnt_q == '0));
endmodule

// File: rtl/drd_resp_sel.sv
module drd_resp_sel
  import drd_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic [2:0]    term,
  input  logic [CW-1:0] xfers,
  input  logic          pref,
  input  logic [CW-1:0] want,
  input  logic [CW-1:0] len,
  input  logic          exhausted,
  output logic          no_data,
  output logic          terminal,
  output logic [1:0]    code,
  output logic [CW-1:0] count,
  output logic          disc,
  output logic          tabort_evt
);
  logic [CW-1:0] got;

  always_comb begin
    no_data    = empty_attempt(term, 16'(xfers));
    got        = CW'(usable(16'(xfers), 16'(len)));
    terminal   = !no_data || exhausted;
    code       = CPL_DATA;
    count      = got;
    disc       = 1'b0;
    tabort_evt = 1'b0;
    if (no_data) begin
      code  = CPL_TIMEOUT;
      count = '0;
    end else begin
      case (term)
        TERM_MABORT: begin
          code  = CPL_MABORT;
          count = '0;
        end
        TERM_TABORT: begin
          code       = CPL_TABORT;
          count      = '0;
          tabort_evt = 1'b1;
        end
        TERM_NORMAL: disc = pref ? (want > got) : 1'b1;
        default:     disc = (want > got);
      endcase
    end
  end
endmodule

// File: rtl/drd_status.sv
module drd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tabort_evt,
  input  logic exhaust_evt,
  input  logic serr_en,
  output logic tgt_rcvd_tabort,
  output logic ini_sig_tabort,
  output logic serr_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_rcvd_tabort <= 1'b0;
      ini_sig_tabort  <= 1'b0;
      serr_pulse      <= 1'b0;
    end else begin
      if (tabort_evt) begin
        tgt_rcvd_tabort <= 1'b1;
        ini_sig_tabort  <= 1'b1;
      end
      serr_pulse <= exhaust_evt && serr_en;
    end
  end

  assert_rta_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rcvd_tabort |=> tgt_rcvd_tabort);
  assert_sta_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ini_sig_tabort |=> ini_sig_tabort);
  assert_serr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |=> !serr_pulse);
endmodule

// File: rtl/drd_retry_ctrl.sv
module drd_retry_ctrl
  import drd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 8,
  parameter int LIMIT = 1 << 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_cmd,
  input  logic          req_pref,
  input  logic [CW-1:0] req_dwords,
  input  logic          cfg_serr_en,
  output logic          att_start,
  output logic [AW-1:0] att_addr,
  output logic [3:0]    att_cmd,
  output logic [CW-1:0] att_dwords,
  input  logic          att_done,
  input  logic [2:0]    att_term,
  input  logic [CW-1:0] att_xfers,
  output logic          cpl_valid,
  output logic [1:0]    cpl_code,
  output logic [CW-1:0] cpl_count,
  output logic          cpl_disc,
  input  logic          cpl_ack,
  output logic          tgt_rcvd_tabort,
  output logic          ini_sig_tabort,
  output logic          serr_pulse
);
  drd_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [3:0]    cmd_q;
  logic          pref_q;
  logic [CW-1:0] want_q;
  logic [CW-1:0] len_q;
  logic [1:0]    code_q;
  logic [CW-1:0] count_q;
  logic          disc_q;

  // named internal events
  logic          accept_evt;
  logic          done_evt;
  logic          no_data;
  logic          terminal;
  logic          exhaust_hit;
  logic          tabort_sel;
  logic [1:0]    sel_code;
  logic [CW-1:0] sel_count;
  logic          sel_disc;

  assign accept_evt = (state_q == ST_IDLE) && req_valid;
  assign done_evt   = (state_q == ST_WAIT) && att_done;

  drd_attempt_ctr #(.LIMIT(LIMIT)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept_evt),
    .inc      (done_evt && no_data),
    .last_hit (exhaust_hit)
  );

  drd_resp_sel #(.CW(CW)) u_sel (
    .term       (att_term),
    .xfers      (att_xfers),
    .pref       (pref_q),
    .want       (want_q),
    .len        (len_q),
    .exhausted  (exhaust_hit),
    .no_data    (no_data),
    .terminal   (terminal),
    .code       (sel_code),
    .count      (sel_count),
    .disc       (sel_disc),
    .tabort_evt (tabort_sel)
  );

  drd_status u_stat (
    .clk             (clk),
    .rst_n           (rst_n),
    .tabort_evt      (done_evt && tabort_sel),
    .exhaust_evt     (done_evt && exhaust_hit),
    .serr_en         (cfg_serr_en),
    .tgt_rcvd_tabort (tgt_rcvd_tabort),
    .ini_sig_tabort  (ini_sig_tabort),
    .serr_pulse      (serr_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cmd_q   <= '0;
      pref_q  <= 1'b0;
      want_q  <= '0;
      len_q   <= '0;
      code_q  <= CPL_DATA;
      count_q <= '0;
      disc_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          cmd_q   <= req_cmd;
          pref_q  <= req_pref;
          want_q  <= req_dwords;
          len_q   <= CW'(attempt_len(req_pref, 16'(req_dwords)));
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (att_done) begin
          if (terminal) begin
            code_q  <= sel_code;
            count_q <= sel_count;
            disc_q  <= sel_disc;
            state_q <= ST_CPL;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        default: if (cpl_ack) state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign att_start  = (state_q == ST_ISSUE);
  assign att_addr   = addr_q;
  assign att_cmd    = cmd_q;
  assign att_dwords = len_q;
  assign cpl_valid  = (state_q == ST_CPL);
  assign cpl_code   = code_q;
  assign cpl_count  = count_q;
  assign cpl_disc   = disc_q;

  assert_cpl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ack) |=> (cpl_valid && $stable(cpl_code) && $stable(cpl_count) && $stable(cpl_disc)));
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (!att_start && !req_ready));
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    att_start |=> !att_start);
  assert_attempt_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(att_addr) && $stable(att_cmd) && $stable(att_dwords)));
  assert_data_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_code == CPL_DATA) |-> (cpl_count != '0 && cpl_count <= att_dwords));
  assert_serr_cpl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_pulse |-> ($rose(cpl_valid) && cpl_code == CPL_TIMEOUT));
endmodule

// File: tb/tb_drd_retry_ctrl.sv
module tb_drd_retry_ctrl;
  localparam int AW = 32;
  localparam int CW = 8;
  localparam int LIM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_cmd = '0;
  logic req_pref = 1'b0;
  logic [CW-1:0] req_dwords = '0;
  logic cfg_serr_en = 1'b0;
  logic att_start;
  logic [AW-1:0] att_addr;
  logic [3:0] att_cmd;
  logic [CW-1:0] att_dwords;
  logic att_done = 1'b0;
  logic [2:0] att_term = '0;
  logic [CW-1:0] att_xfers = '0;
  logic cpl_valid;
  logic [1:0] cpl_code;
  logic [CW-1:0] cpl_count;
  logic cpl_disc;
  logic cpl_ack = 1'b0;
  logic tgt_rcvd_tabort, ini_sig_tabort, serr_pulse;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  drd_retry_ctrl #(.AW(AW), .CW(CW), .LIMIT(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cmd(req_cmd), .req_pref(req_pref), .req_dwords(req_dwords),
    .cfg_serr_en(cfg_serr_en), .att_start(att_start), .att_addr(att_addr), .att_cmd(att_cmd),
    .att_dwords(att_dwords), .att_done(att_done), .att_term(att_term), .att_xfers(att_xfers),
    .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_count(cpl_count), .cpl_disc(cpl_disc),
    .cpl_ack(cpl_ack), .tgt_rcvd_tabort(tgt_rcvd_tabort), .ini_sig_tabort(ini_sig_tabort),
    .serr_pulse(serr_pulse)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  logic [AW-1:0] cur_addr;
  logic [3:0]    cur_cmd;
  logic [CW-1:0] cur_len;

  task automatic send(input logic [AW-1:0] a, input logic [3:0] c, input logic p, input logic [CW-1:0] n);
    chk(req_ready, "R10 ready before request", req_ready, 1);
    req_addr = a; req_cmd = c; req_pref = p; req_dwords = n; req_valid = 1'b1;
    cur_addr = a; cur_cmd = c; cur_len = p ? n : 8'd1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // wait for an attempt, check its fields, answer it
  task automatic answer(input logic [2:0] t, input logic [CW-1:0] x);
    int n = 0;
    while (!att_start && n < 20) begin @(negedge clk); n++; end
    chk(att_start, "R3 attempt issued", att_start, 1);
    chk(att_addr == cur_addr, "R2 attempt address", att_addr, cur_addr);
    chk(att_cmd == cur_cmd, "R2 attempt command", att_cmd, cur_cmd);
    chk(att_dwords == cur_len, "R2 attempt length", att_dwords, cur_len);
    @(negedge clk);
    att_done = 1'b1; att_term = t; att_xfers = x;
    @(negedge clk);
    att_done = 1'b0; att_term = '0; att_xfers = '0;
  endtask

  task automatic expect_cpl(input logic [1:0] code, input logic [CW-1:0] cnt, input logic disc, input string tag);
    chk(cpl_valid, {tag, " completion valid"}, cpl_valid, 1);
    chk(cpl_code == code, {tag, " code"}, cpl_code, code);
    chk(cpl_count == cnt, {tag, " count"}, cpl_count, cnt);
    chk(cpl_disc == disc, {tag, " disconnect"}, cpl_disc, disc);
  endtask

  task automatic ack;
    cpl_ack = 1'b1;
    @(negedge clk);
    cpl_ack = 1'b0;
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(!cpl_valid && !att_start, "R1 idle outputs", {cpl_valid, att_start}, 0);
    chk(!serr_pulse && !tgt_rcvd_tabort && !ini_sig_tabort, "R1 status",
        {serr_pulse, tgt_rcvd_tabort, ini_sig_tabort}, 0);
  endtask

  task automatic t_pref_normal;
    send(32'h1000, 4'h6, 1'b1, 8'd4);
    answer(3'd0, 8'd4);
    expect_cpl(2'd0, 8'd4, 1'b0, "R4 full fetch");
    ack();
    send(32'h2000, 4'hC, 1'b1, 8'd8);
    answer(3'd0, 8'd3);
    expect_cpl(2'd0, 8'd3, 1'b1, "R4 short fetch");
    ack();
  endtask

  task automatic t_nonpref;
    send(32'h3000, 4'h6, 1'b0, 8'd6);
    chk(1'b1, "R5 length one", 0, 0);
    answer(3'd0, 8'd1);
    expect_cpl(2'd0, 8'd1, 1'b1, "R5 nonpref");
    ack();
  endtask

  task automatic t_retry;
    send(32'h4400, 4'hE, 1'b1, 8'd5);
    answer(3'd1, 8'd0);
    chk(att_start, "R3 immediate reissue", att_start, 1);
    answer(3'd2, 8'd0);
    chk(att_start && !cpl_valid, "R3 zero-data disconnect repeats", att_start, 1);
    answer(3'd0, 8'd0);
    chk(att_start && !cpl_valid, "R3 zero-data normal repeats", att_start, 1);
    answer(3'd0, 8'd5);
    expect_cpl(2'd0, 8'd5, 1'b0, "R2 after retries");
    ack();
  endtask

  task automatic t_disconnect;
    send(32'h5000, 4'h6, 1'b1, 8'd6);
    answer(3'd2, 8'd2);
    expect_cpl(2'd0, 8'd2, 1'b1, "R6 partial");
    ack();
    send(32'h5100, 4'h6, 1'b1, 8'd5);
    answer(3'd2, 8'd5);
    expect_cpl(2'd0, 8'd5, 1'b0, "R6 complete");
    ack();
  endtask

  task automatic t_mabort_hold;
    send(32'h6000, 4'h6, 1'b1, 8'd2);
    answer(3'd4, 8'd0);
    expect_cpl(2'd1, 8'd0, 1'b0, "R7 master abort");
    chk(!tgt_rcvd_tabort && !ini_sig_tabort, "R7 status untouched", tgt_rcvd_tabort, 0);
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    expect_cpl(2'd1, 8'd0, 1'b0, "R10 held");
    chk(!req_ready, "R10 not ready while busy", req_ready, 0);
    ack();
    repeat (3) begin
      chk(!att_start && !cpl_valid, "R10 busy request ignored", att_start, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_limit(input logic en);
    cfg_serr_en = en;
    send(32'h7000, 4'h6, 1'b1, 8'd3);
    for (int i = 0; i < LIM; i++) begin
      chk(!serr_pulse, "R9 no early error", serr_pulse, 0);
      answer(3'd1, 8'd0);
    end
    expect_cpl(2'd3, 8'd0, 1'b0, "R9 exhausted");
    chk(!att_start, "R9 no extra attempt", att_start, 0);
    chk(serr_pulse == en, "R9 error pulse", serr_pulse, en);
    @(negedge clk);
    chk(!serr_pulse, "R9 pulse one cycle", serr_pulse, 0);
    ack();
  endtask

  task automatic t_tabort;
    send(32'h8000, 4'h6, 1'b1, 8'd4);
    answer(3'd3, 8'd0);
    expect_cpl(2'd2, 8'd0, 1'b0, "R8 target abort");
    chk(tgt_rcvd_tabort && ini_sig_tabort, "R8 both flags", {tgt_rcvd_tabort, ini_sig_tabort}, 3);
    ack();
    send(32'h8100, 4'h6, 1'b1, 8'd1);
    answer(3'd0, 8'd1);
    expect_cpl(2'd0, 8'd1, 1'b0, "R4 single dword");
    chk(tgt_rcvd_tabort && ini_sig_tabort, "R8 flags sticky", {tgt_rcvd_tabort, ini_sig_tabort}, 3);
    ack();
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pref_normal();
    t_nonpref();
    t_retry();
    t_disconnect();
    t_mabort_hold();
    t_limit(1'b1);
    t_limit(1'b0);
    t_tabort();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule